// File: doc/BRIEF.md
# Packed 16-bit Lane Compare Unit

This unit decodes and executes five packed compare instructions on two register operands. Each operand is split into independent 16-bit lanes. Every lane of the result is a full mask: all ones where the comparison holds and all zeros where it does not. The five comparisons are equality, signed less-than, signed less-or-equal, unsigned less-than and unsigned less-or-equal.

Each cycle the unit takes a 32-bit instruction word, two XLEN-wide operands and a valid strobe. One clock later it returns either a registered result with a result-valid strobe or an illegal-instruction flag. The destination and source register fields travel with the result for use by downstream writeback. The unit never stalls, so a new instruction may enter on every cycle. XLEN is 32 (two lanes) or 64 (four lanes).

Top module: `pcmp16_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, out_valid, out_illegal, out_result and the three field outputs are all zero.
- R2: An instruction is accepted when in_valid is high, instr[6:0] = 1110111, instr[14:12] = 000 and instr[31:25] is one of the five operation codes. Exactly one clock later out_valid is high and out_illegal is low.
- R3: Operation code 0100110 (equal) writes 0xFFFF to a lane whose two operand lanes are bit-identical and 0x0000 otherwise.
- R4: Operation code 0000110 (signed less-than) writes 0xFFFF to a lane when the lane of opnd_a, read as a two's-complement 16-bit value, is less than the lane of opnd_b.
- R5: Operation code 0001110 (signed less-or-equal) writes 0xFFFF to a lane when the signed lane of opnd_a is less than or equal to the signed lane of opnd_b.
- R6: Operation code 0010110 (unsigned less-than) writes 0xFFFF to a lane when the lane of opnd_a, read as an unsigned 16-bit value, is less than the lane of opnd_b.
- R7: Operation code 0011110 (unsigned less-or-equal) writes 0xFFFF to a lane when the unsigned lane of opnd_a is less than or equal to the unsigned lane of opnd_b.
- R8: The unit has XLEN/16 lanes, and lane i occupies bits [16i+15:16i]. Each result lane depends only on the same lane of the two operands and is always either 0xFFFF or 0x0000.
- R9: Any other instruction word presented with in_valid sets out_illegal for exactly one cycle, one clock later. In that cycle out_valid is low and out_result is zero. This covers a different major opcode, a nonzero funct3 and an unlisted operation code.
- R10: A cycle without in_valid produces, one clock later, out_valid low, out_illegal low and out_result zero.
- R11: For an accepted instruction, out_rd, out_rs1 and out_rs2 carry instr[11:7], instr[19:15] and instr[24:20] in the same cycle as the result. These fields do not affect out_result.
- R12: Instructions presented on consecutive cycles each produce their own output in consecutive cycles, with no stall or gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present |
| instr | input | 32 | Instruction word |
| opnd_a | input | XLEN | First source operand |
| opnd_b | input | XLEN | Second source operand |
| out_valid | output | 1 | Registered result is valid |
| out_illegal | output | 1 | Previous instruction was not recognised |
| out_result | output | XLEN | Packed lane masks |
| out_rd | output | 5 | Destination register field |
| out_rs1 | output | 5 | First source register field |
| out_rs2 | output | 5 | Second source register field |

## Verification
Each of the five operations is swept over every pairing of a boundary value set: zero, one, the largest and smallest signed values with their neighbours, all ones and one mid-range value. These pairs tell signed from unsigned ordering (0x8000 against 0x7FFF) and strict from non-strict ordering (equal pairs). The upper lane gets a different pairing from the lower one, so any crosstalk between lanes or a swapped lane shows up. Every 7-bit operation code with funct3 zero is then decoded, together with nonzero funct3 values and a foreign opcode. Instructions are streamed back to back with changing register fields, which checks field pass-through and single-cycle throughput.

// File: rtl/pcmp16_pkg.sv
package pcmp16_pkg;
  localparam logic [6:0] PCMP_OPCODE = 7'b1110111;
  localparam logic [2:0] PCMP_F3     = 3'b000;

  localparam logic [6:0] F7_EQ  = 7'b0100110;
  localparam logic [6:0] F7_SLT = 7'b0000110;
  localparam logic [6:0] F7_SLE = 7'b0001110;
  localparam logic [6:0] F7_ULT = 7'b0010110;
  localparam logic [6:0] F7_ULE = 7'b0011110;

  localparam int unsigned LANE_W = 16;

  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_SLT = 3'd1,
    CMP_SLE = 3'd2,
    CMP_ULT = 3'd3,
    CMP_ULE = 3'd4
  } cmp_op_e;
endpackage

// File: rtl/pcmp16_decode.sv
module pcmp16_decode
  import pcmp16_pkg::*;
(
  input  logic        in_valid,
  input  logic [31:0] instr,
  output logic        accept,
  output logic        reject,
  output cmp_op_e     op
);
  logic       form_ok;
  logic       code_ok;
  logic [6:0] f7;

  assign f7      = instr[31:25];
  assign form_ok = (instr[6:0] == PCMP_OPCODE) && (instr[14:12] == PCMP_F3);

  always_comb begin
    code_ok = 1'b1;
    op      = CMP_EQ;
    unique case (f7)
      F7_EQ:   op = CMP_EQ;
      F7_SLT:  op = CMP_SLT;
      F7_SLE:  op = CMP_SLE;
      F7_ULT:  op = CMP_ULT;
      F7_ULE:  op = CMP_ULE;
      default: code_ok = 1'b0;
    endcase
  end

  assign accept = in_valid && form_ok && code_ok;
  assign reject = in_valid && !(form_ok && code_ok);
endmodule

// File: rtl/pcmp16_lane.sv
module pcmp16_lane
  import pcmp16_pkg::*;
(
  input  cmp_op_e            op,
  input  logic [LANE_W-1:0]  a,
  input  logic [LANE_W-1:0]  b,
  output logic [LANE_W-1:0]  mask
);
  logic eq, slt, ult, hit;

  assign eq  = (a == b);
  assign slt = ($signed(a) < $signed(b));
  assign ult = (a < b);

  always_comb begin
    unique case (op)
      CMP_EQ:  hit = eq;
      CMP_SLT: hit = slt;
      CMP_SLE: hit = slt | eq;
      CMP_ULT: hit = ult;
      CMP_ULE: hit = ult | eq;
      default: hit = 1'b0;
    endcase
  end

  assign mask = {LANE_W{hit}};
endmodule

// File: rtl/pcmp16_unit.sv
module pcmp16_unit
  import pcmp16_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  output logic            out_valid,
  output logic            out_illegal,
  output logic [XLEN-1:0] out_result,
  output logic [4:0]      out_rd,
  output logic [4:0]      out_rs1,
  output logic [4:0]      out_rs2
);
  localparam int unsigned NLANES = XLEN / LANE_W;

  logic            accept, reject;
  cmp_op_e         op;
  logic [XLEN-1:0] lane_res;

  pcmp16_decode u_dec (
    .in_valid (in_valid),
    .instr    (instr),
    .accept   (accept),
    .reject   (reject),
    .op       (op)
  );

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    pcmp16_lane u_lane (
      .op   (op),
      .a    (opnd_a[g*LANE_W +: LANE_W]),
      .b    (opnd_b[g*LANE_W +: LANE_W]),
      .mask (lane_res[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
      out_rd      <= '0;
      out_rs1     <= '0;
      out_rs2     <= '0;
    end else begin
      out_valid   <= accept;
      out_illegal <= reject;
      out_result  <= accept ? lane_res : '0;
      out_rd      <= accept ? instr[11:7]  : 5'd0;
      out_rs1     <= accept ? instr[19:15] : 5'd0;
      out_rs2     <= accept ? instr[24:20] : 5'd0;
    end
  end
endmodule

// File: rtl/pcmp16_chk.sv
module pcmp16_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] opnd_a,
  input logic [XLEN-1:0] opnd_b,
  input logic            out_valid,
  input logic            out_illegal,
  input logic [XLEN-1:0] out_result,
  input logic [4:0]      out_rd
);
  localparam int unsigned NL = XLEN / 16;

  logic lanes_full;
  always_comb begin
    lanes_full = 1'b1;
    for (int i = 0; i < NL; i++) begin
      if (out_result[i*16 +: 16] != 16'h0000 && out_result[i*16 +: 16] != 16'hFFFF)
        lanes_full = 1'b0;
    end
  end

  logic eq_issue;
  assign eq_issue = in_valid && instr == {7'b0100110, instr[24:7], 7'b1110111}
                    && instr[14:12] == 3'b000 && opnd_a == opnd_b;

  AST_LANE_MASK: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> lanes_full); // R8
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_illegal)); // R9
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_result == '0); // R9
  AST_FOREIGN_OP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[6:0] != 7'b1110111) |=> out_illegal); // R9
  AST_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_illegal)); // R10
  AST_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid || out_illegal)); // R12
  AST_EQ_SELF: assert property (@(posedge clk) disable iff (rst)
    eq_issue |=> (out_valid && out_result == {XLEN{1'b1}})); // R3
  AST_RD_PASS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (!out_valid || out_rd == $past(instr[11:7]))); // R11
endmodule

bind pcmp16_unit pcmp16_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .instr       (instr),
  .opnd_a      (opnd_a),
  .opnd_b      (opnd_b),
  .out_valid   (out_valid),
  .out_illegal (out_illegal),
  .out_result  (out_result),
  .out_rd      (out_rd)
);

// File: tb/pcmp16_unit_tb.sv
`timescale 1ns/1ps
module pcmp16_unit_tb;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid;
  logic [31:0]     instr;
  logic [XLEN-1:0] opnd_a, opnd_b;
  logic            out_valid, out_illegal;
  logic [XLEN-1:0] out_result;
  logic [4:0]      out_rd, out_rs1, out_rs2;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pcmp16_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
    .out_illegal(out_illegal), .out_result(out_result),
    .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2)
  );

  logic [15:0] vals [8];
  logic [6:0]  f7s  [5];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int sval(input logic [15:0] v);
    return (v >= 16'h8000) ? int'(v) - 65536 : int'(v);
  endfunction

  function automatic bit cmp(input int op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      0: return a == b;
      1: return sval(a) < sval(b);
      2: return sval(a) <= sval(b);
      3: return int'(a) < int'(b);
      default: return int'(a) <= int'(b);
    endcase
  endfunction

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3,
                                     input logic [6:0] opc, input int k);
    logic [4:0] rd, r1, r2;
    rd = 5'(k + 3); r1 = 5'(~k); r2 = 5'(k);
    return {f7, r2, r1, f3, rd, opc};
  endfunction

  function automatic string rtag(input int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic issue(input logic v, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = v; instr = ins; opnd_a = a; opnd_b = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h7FFE, 16'h8001, 16'h1234};
    f7s  = '{7'b0100110, 7'b0000110, 7'b0001110, 7'b0010110, 7'b0011110};
    rst = 1'b1; in_valid = 1'b0; instr = '0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", {out_valid, out_illegal, out_rd, out_rs1, out_rs2, out_result},
        64'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 after release", {out_valid, out_illegal, out_result}, 64'd0);

    // R3..R8, R11, R12: streamed sweep, one instruction per cycle
    for (int op = 0; op < 5; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          int k;
          logic [15:0] a0, b0, a1, b1;
          logic [31:0] ins, expv;
          k = op * 64 + i * 8 + j;
          a0 = vals[i]; b0 = vals[j];
          a1 = vals[j]; b1 = vals[(i + 3) % 8];
          ins = mk(f7s[op], 3'b000, 7'b1110111, k);
          expv = {{16{cmp(op, a1, b1)}}, {16{cmp(op, a0, b0)}}};
          issue(1'b1, ins, {a1, a0}, {b1, b0});
          chk({rtag(op), " R8 lane result"}, out_result, expv);
          chk("R2 R12 valid", {out_valid, out_illegal}, 2'b10);
          chk("R11 fields", {out_rd, out_rs1, out_rs2},
              {ins[11:7], ins[19:15], ins[24:20]});
        end
      end
    end

    // R10: idle cycle
    issue(1'b0, mk(f7s[0], 3'b000, 7'b1110111, 1), 32'h5, 32'h5);
    chk("R10 idle", {out_valid, out_illegal, out_result}, 64'd0);

    // R2, R9: full funct7 decode sweep
    for (int f = 0; f < 128; f++) begin
      bit legal;
      legal = 0;
      for (int q = 0; q < 5; q++) if (f7s[q] == 7'(f)) legal = 1;
      issue(1'b1, mk(7'(f), 3'b000, 7'b1110111, f), 32'h0001_8000, 32'h0001_8000);
      if (legal)
        chk("R2 decode legal", {out_valid, out_illegal}, 2'b10);
      else
        chk("R9 unlisted funct7", {out_valid, out_illegal, out_result}, {2'b01, 32'd0});
    end
    for (int f3 = 1; f3 < 8; f3++) begin
      issue(1'b1, mk(f7s[0], 3'(f3), 7'b1110111, f3), 32'h0, 32'h0);
      chk("R9 nonzero funct3", {out_valid, out_illegal, out_result}, {2'b01, 32'd0});
    end
    issue(1'b1, mk(f7s[0], 3'b000, 7'b0110011, 2), 32'h0, 32'h0);
    chk("R9 foreign opcode", {out_valid, out_illegal, out_result}, {2'b01, 32'd0});
    issue(1'b0, 32'h0, 32'h0, 32'h0);
    chk("R9 illegal one cycle", {out_valid, out_illegal}, 2'b00);

    // R11: fields do not change the result
    issue(1'b1, mk(f7s[3], 3'b000, 7'b1110111, 9), 32'h8000_0001, 32'h0001_8000);
    chk("R11 result fields A", out_result, 32'h0000_FFFF);
    issue(1'b1, mk(f7s[3], 3'b000, 7'b1110111, 22), 32'h8000_0001, 32'h0001_8000);
    chk("R11 result fields B", out_result, 32'h0000_FFFF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule